// File: doc/BRIEF.md
# Sync Object Counter Array

This block holds a bank of small counters, one per sync object, that completion sources update using ordinary register writes. Each write port carries a byte address and a 32-bit data word. The address selects one object by word index. The data word selects one of two operations: overwrite the object with a new value, or add a signed amount to the object's current value. Because the amount has a sign, a plain write can also decrement an object. Monitor logic that watches these counters can therefore re-arm itself by writing a minus-one back to the object.

Every object's current value is driven out in parallel for monitor logic. A combinational read port returns any single object. Several write ports can update the bank in the same cycle. When two or more ports target the same object, their operations are applied in a fixed port order within that cycle, so no update is lost.

Top module: `sobj_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every object reads zero until a write reaches it. Reset is active low and asynchronous.
- R2: The object index is taken from address bits [ADDR_W-1:2], so objects sit 4 bytes apart. Address bits 1:0 have no effect.
- R3: When data bit 31 is 0, the write overwrites the object with data bits 14:0. Data bits 30:15 are ignored.
- R4: When data bit 31 is 1, the write adds the 16-bit two's-complement amount formed by data bits 15:0 (bit 15 is the sign) to the object, modulo 2^15. Data bits 30:16 are ignored. Value 1 with sign 0 adds one.
- R5: An increment write of value 0x7FFF with sign 1 subtracts one. Applied to an object that holds zero, it gives 0x7FFF.
- R6: An increment that carries past 0x7FFF wraps the stored count modulo 2^15. For example, 0x7FFF plus 1 gives 0.
- R7: A write presented at a rising clock edge is visible on the object outputs and the read port right after that edge. There is no extra latency.
- R8: Writes from several ports to one object in the same cycle are applied in ascending port order, each on the result of the one before. Two increments both count. A later-port overwrite wins over an earlier increment. A later-port increment adds to an earlier overwrite.
- R9: A write whose index is at or above NUM_OBJ changes no object. An object that no valid write addresses keeps its value.
- R10: The read port returns the addressed object's 15-bit value zero-extended to 32 bits, in the same cycle the read address is presented. An index at or above NUM_OBJ reads as 0.
- R11: Writes from different ports to different objects in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | NUM_PORTS | Per-port write strobe |
| wr_addr | input | NUM_PORTS*ADDR_W | Per-port byte address, port p in bits [p*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_PORTS*32 | Per-port write word, port p in bits [p*32 +: 32] |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Zero-extended value of the addressed object |
| obj_vals | output | NUM_OBJ*15 | All object values, object k in bits [k*15 +: 15] |

## Verification
The bench targets the wrap points of the 15-bit count. It decrements an object that holds zero and increments an object that holds 0x7FFF. A design that carried or borrowed into a wider register, or that saturated, would show 0x8000-style values or stick at the limit. It sends same-cycle collisions on one object in every mix of overwrite and increment. A design with a single winning port, or with the wrong port order, would drop an increment or keep the wrong value. It also sets the ignored data bits, the sign bit on overwrites, the low address bits and out-of-range indices. These catch a design that decodes the wrong bit field or that aliases high indices onto real objects.

// File: rtl/sobj_pkg.sv
package sobj_pkg;
   localparam int WORD_W   = 32;
   localparam int CNT_W    = 15;
   localparam int AMT_W    = 16;
   localparam int SIGN_POS = 15;
   localparam int INC_POS  = 31;

   typedef logic [CNT_W-1:0] cnt_t;
   typedef logic [AMT_W-1:0] amt_t;

   // One operation applied to a current count: overwrite or signed add.
   function automatic cnt_t apply_op(input cnt_t cur, input logic is_inc, input amt_t amt);
      logic signed [AMT_W:0] sum;
      if (is_inc) begin
         sum = $signed({2'b00, cur}) + $signed({amt[AMT_W-1], amt});
         return sum[CNT_W-1:0];
      end
      return amt[CNT_W-1:0];
   endfunction
endpackage

// File: rtl/sobj_wr_decode.sv
module sobj_wr_decode
   import sobj_pkg::*;
#(
   parameter int NUM_OBJ = 16,
   parameter int ADDR_W  = 8
) (
   input  logic               valid,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [WORD_W-1:0]  data,
   output logic [NUM_OBJ-1:0] hit,
   output logic               is_inc,
   output amt_t               amt
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             in_range;

   assign idx      = addr[ADDR_W-1:2];
   assign in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_OBJ));
   assign is_inc   = data[INC_POS];
   assign amt      = {data[SIGN_POS], data[CNT_W-1:0]};

   for (genvar k = 0; k < NUM_OBJ; k++) begin : g_hit
      assign hit[k] = valid && in_range && (idx == IDX_W'(k));
   end
endmodule

// File: rtl/sobj_update.sv
module sobj_update
   import sobj_pkg::*;
#(
   parameter int NUM_PORTS = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PORTS-1:0]       hit,
   input  logic [NUM_PORTS-1:0]       is_inc,
   input  logic [NUM_PORTS*AMT_W-1:0] amt_flat,
   output cnt_t                       cnt_q
);
   cnt_t cnt_d;

   // Ports applied in ascending order within one cycle.
   always_comb begin
      cnt_d = cnt_q;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (hit[p]) cnt_d = apply_op(cnt_d, is_inc[p], amt_flat[p*AMT_W +: AMT_W]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   a_r9_hold_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |=> (cnt_q == $past(cnt_q)));

   a_r3_overwrite_port0: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == NUM_PORTS'(1) && !is_inc[0]) |=> (cnt_q == $past(amt_flat[CNT_W-1:0])));

   a_r4_increment_port0: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == NUM_PORTS'(1) && is_inc[0])
      |=> (cnt_q == CNT_W'($past(cnt_q) + $past(amt_flat[CNT_W-1:0]))));

   if (NUM_PORTS >= 2) begin : g_pair_chk
      a_r8_two_increments: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[1:0] == 2'b11 && $countones(hit) == 2 && is_inc[0] && is_inc[1])
         |=> (cnt_q == CNT_W'($past(cnt_q) + $past(amt_flat[CNT_W-1:0])
                              + $past(amt_flat[AMT_W +: CNT_W]))));
   end
endmodule

// File: rtl/sobj_read_mux.sv
module sobj_read_mux
   import sobj_pkg::*;
#(
   parameter int NUM_OBJ = 16,
   parameter int ADDR_W  = 8
) (
   input  logic [ADDR_W-1:0]        rd_addr,
   input  logic [NUM_OBJ*CNT_W-1:0] vals,
   output logic [WORD_W-1:0]        rd_data
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] ridx;
   cnt_t             sel;

   assign ridx = rd_addr[ADDR_W-1:2];

   always_comb begin
      sel = '0;
      for (int k = 0; k < NUM_OBJ; k++) begin
         if (ridx == IDX_W'(k)) sel = vals[k*CNT_W +: CNT_W];
      end
   end

   assign rd_data = {{(WORD_W-CNT_W){1'b0}}, sel};
endmodule

// File: rtl/sobj_bank.sv
module sobj_bank
   import sobj_pkg::*;
#(
   parameter int NUM_OBJ   = 16,
   parameter int NUM_PORTS = 2,
   parameter int ADDR_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS-1:0]        wr_valid,
   input  logic [NUM_PORTS*ADDR_W-1:0] wr_addr,
   input  logic [NUM_PORTS*32-1:0]     wr_data,
   input  logic [ADDR_W-1:0]           rd_addr,
   output logic [31:0]                 rd_data,
   output logic [NUM_OBJ*15-1:0]       obj_vals
);
   localparam int IDX_W = ADDR_W - 2;

   if (NUM_OBJ < 1)                 begin : g_bad_obj   $error("NUM_OBJ must be at least 1"); end
   if (NUM_PORTS < 1)               begin : g_bad_ports $error("NUM_PORTS must be at least 1"); end
   if (ADDR_W < 3)                  begin : g_bad_aw    $error("ADDR_W must be at least 3"); end
   if (NUM_OBJ > (1 << (ADDR_W-2))) begin : g_bad_span  $error("NUM_OBJ exceeds address span"); end

   logic [NUM_OBJ-1:0]         p_hit [NUM_PORTS];
   logic [NUM_PORTS-1:0]       p_inc;
   logic [NUM_PORTS*AMT_W-1:0] p_amt;
   logic [NUM_PORTS-1:0]       o_hit [NUM_OBJ];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      sobj_wr_decode #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W)) u_dec (
         .valid  (wr_valid[p]),
         .addr   (wr_addr[p*ADDR_W +: ADDR_W]),
         .data   (wr_data[p*WORD_W +: WORD_W]),
         .hit    (p_hit[p]),
         .is_inc (p_inc[p]),
         .amt    (p_amt[p*AMT_W +: AMT_W])
      );
      for (genvar k = 0; k < NUM_OBJ; k++) begin : g_xpose
         assign o_hit[k][p] = p_hit[p][k];
      end
   end

   for (genvar k = 0; k < NUM_OBJ; k++) begin : g_obj
      sobj_update #(.NUM_PORTS(NUM_PORTS)) u_upd (
         .clk      (clk),
         .rst_n    (rst_n),
         .hit      (o_hit[k]),
         .is_inc   (p_inc),
         .amt_flat (p_amt),
         .cnt_q    (obj_vals[k*CNT_W +: CNT_W])
      );
   end

   sobj_read_mux #(.NUM_OBJ(NUM_OBJ), .ADDR_W(ADDR_W)) u_rd (
      .rd_addr (rd_addr),
      .vals    (obj_vals),
      .rd_data (rd_data)
   );

   // Checks tied to the ports.
   logic any_in_range;
   always_comb begin
      any_in_range = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (wr_valid[p] && ({1'b0, wr_addr[p*ADDR_W+2 +: IDX_W]} < (IDX_W+1)'(NUM_OBJ)))
            any_in_range = 1'b1;
      end
   end

   a_r9_out_of_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !any_in_range |=> (obj_vals == $past(obj_vals)));

   a_r10_read_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[31:CNT_W] == '0);

   a_r10_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, rd_addr[ADDR_W-1:2]} >= (IDX_W+1)'(NUM_OBJ)) |-> (rd_data == '0));
endmodule

// File: tb/sobj_bank_test.sv
`timescale 1ns/1ps
module sobj_bank_test;
   localparam int NO = 16;
   localparam int NP = 2;
   localparam int AW = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     wr_valid = '0;
   logic [NP*AW-1:0]  wr_addr = '0;
   logic [NP*32-1:0]  wr_data = '0;
   logic [AW-1:0]     rd_addr = '0;
   logic [31:0]       rd_data;
   logic [NO*15-1:0]  obj_vals;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [14:0] exp_v [NO];

   sobj_bank #(.NUM_OBJ(NO), .NUM_PORTS(NP), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .obj_vals(obj_vals)
   );

   always #2.5 clk = ~clk;

   function automatic logic [31:0] mk(input logic inc, input logic sgn, input logic [14:0] v);
      return {inc, 15'h0, sgn, v};
   endfunction

   // Expected-value model from R2-R6, R8, R9.
   function automatic void model(input logic [AW-1:0] a, input logic [31:0] d);
      int idx = int'(a[AW-1:2]);
      logic [15:0] s;
      if (idx >= NO) return;
      if (d[31]) begin
         s = {1'b0, exp_v[idx]} + {d[15], d[14:0]};
         exp_v[idx] = s[14:0];
      end else exp_v[idx] = d[14:0];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      for (int k = 0; k < NO; k++)
         chk(tag, {17'h0, obj_vals[k*15 +: 15]}, {17'h0, exp_v[k]});
   endtask

   // Drive up to two writes for one edge, update the model in port order.
   task automatic wr2(input logic v0, input logic [AW-1:0] a0, input logic [31:0] d0,
                      input logic v1, input logic [AW-1:0] a1, input logic [31:0] d1);
      @(negedge clk);
      wr_valid = {v1, v0};
      wr_addr  = {a1, a0};
      wr_data  = {d1, d0};
      @(posedge clk);
      @(negedge clk);
      wr_valid = '0;
      if (v0) model(a0, d0);
      if (v1) model(a1, d1);
   endtask

   task automatic rd(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      for (int k = 0; k < NO; k++) exp_v[k] = '0;
      repeat (2) @(negedge clk);
      chk_all("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1 after release");
      rd("R1 read", 8'd12, 32'h0);
   endtask

   task automatic t_overwrite;
      wr2(1, 8'(3*4), mk(0, 0, 15'h1234), 0, '0, '0);
      chk_all("R7 overwrite visible next cycle");
      chk({17'h0, obj_vals[3*15 +: 15]}, 32'h1234, 32'h1234);
      // sign set, junk in 30:16, low address bits set
      wr2(0, '0, '0, 1, 8'(5*4+2), 32'h7FFF_8555);
      chk("R3 ignored bits on overwrite", {17'h0, obj_vals[5*15 +: 15]}, 32'h555);
      chk("R2 low address bits ignored", {17'h0, obj_vals[4*15 +: 15]}, 32'h0);
      chk_all("R3 overwrite");
   endtask

   task automatic t_increment;
      wr2(1, 8'(3*4), mk(1, 0, 15'h1), 0, '0, '0);
      chk("R4 increment by one", {17'h0, obj_vals[3*15 +: 15]}, 32'h1235);
      wr2(1, 8'(3*4+1), 32'hFFFF_0001, 0, '0, '0);
      chk("R4 ignored bits on increment", {17'h0, obj_vals[3*15 +: 15]}, 32'h1236);
      wr2(0, '0, '0, 1, 8'(3*4), mk(1, 0, 15'h100));
      chk_all("R4 increment by amount");
   endtask

   task automatic t_decrement;
      wr2(1, 8'(7*4), mk(1, 1, 15'h7FFF), 0, '0, '0);
      chk("R5 decrement from zero", {17'h0, obj_vals[7*15 +: 15]}, 32'h7FFF);
      wr2(1, 8'(7*4), mk(1, 1, 15'h7FFF), 0, '0, '0);
      chk("R5 decrement again", {17'h0, obj_vals[7*15 +: 15]}, 32'h7FFE);
      wr2(1, 8'(3*4), mk(1, 1, 15'h7FFF), 0, '0, '0);
      chk_all("R5 decrement");
   endtask

   task automatic t_wrap;
      wr2(1, 8'(9*4), mk(0, 0, 15'h7FFF), 0, '0, '0);
      wr2(1, 8'(9*4), mk(1, 0, 15'h1), 0, '0, '0);
      chk("R6 wrap to zero", {17'h0, obj_vals[9*15 +: 15]}, 32'h0);
      wr2(1, 8'(9*4), mk(1, 0, 15'h7FFE), 0, '0, '0);
      wr2(1, 8'(9*4), mk(1, 1, 15'h0002), 0, '0, '0);
      chk_all("R6 large signed add");
   endtask

   task automatic t_collide;
      wr2(1, 8'(2*4), mk(1, 0, 15'h1), 1, 8'(2*4), mk(1, 0, 15'h3));
      chk("R8 two increments", {17'h0, obj_vals[2*15 +: 15]}, 32'h4);
      wr2(1, 8'(2*4), mk(1, 0, 15'h9), 1, 8'(2*4), mk(0, 0, 15'h50));
      chk("R8 later overwrite wins", {17'h0, obj_vals[2*15 +: 15]}, 32'h50);
      wr2(1, 8'(2*4), mk(0, 0, 15'h20), 1, 8'(2*4), mk(1, 0, 15'h5));
      chk("R8 increment after overwrite", {17'h0, obj_vals[2*15 +: 15]}, 32'h25);
      wr2(1, 8'(2*4), mk(0, 0, 15'h11), 1, 8'(2*4+3), mk(0, 0, 15'h22));
      chk("R8 two overwrites", {17'h0, obj_vals[2*15 +: 15]}, 32'h22);
      chk_all("R8 collision others");
   endtask

   task automatic t_oor;
      wr2(1, 8'(16*4), mk(0, 0, 15'h1), 1, 8'(63*4), mk(1, 0, 15'h1));
      chk_all("R9 out of range ignored");
      rd("R10 out of range read", 8'(20*4), 32'h0);
   endtask

   task automatic t_parallel;
      wr2(1, 8'(0*4), mk(0, 0, 15'h0AAA), 1, 8'(15*4), mk(0, 0, 15'h7555));
      chk_all("R11 parallel writes");
   endtask

   task automatic t_read;
      for (int k = 0; k < NO; k++) rd("R10 read each", 8'(k*4 + (k % 4)), {17'h0, exp_v[k]});
   endtask

   initial begin
      t_reset;
      t_overwrite;
      t_increment;
      t_decrement;
      t_wrap;
      t_collide;
      t_oor;
      t_parallel;
      t_read;
      t_reset;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule